// File: doc/BRIEF.md
# Refresh-Counter Test Access Controller

This block is the control logic inside a 1M x 4 fast-page dynamic memory that recognises refresh cycles started by the column strobe and a special test access that can follow them. All strobes are active low and are sampled on the device clock. If the column strobe is already low when the row strobe falls, the cycle is a refresh. The row for that refresh comes from an internal 10-bit refresh row counter. A cycle where the row strobe falls while the column strobe is high is a row-only refresh. In this model that cycle loads the counter from the address pins, so a test can place the counter at a known row.

A refresh can stay open with the row strobe low while the column strobe goes high and then low again. That second fall opens a test access. Its row is the current counter value and its column is the address on the pins at that fall. The access can be a write, a read, or a read-modify-write. The counter steps by one when the refresh cycle ends. A full sweep of refresh-generated rows can therefore be written and read back, which exercises the refresh addressing.

The storage behind the controller is a small behavioural array. It is indexed by the low bits of the row and column. The data bus is split into an input, an output and an output-enable. A low output-enable stands for a high-impedance bus.

Top module: `cbr_test_ctrl`

## Requirements
- R1: The row strobe is sampled low on a clock edge. If the column strobe was sampled low on the previous edge, the cycle is decoded as a refresh cycle. During that refresh the block does not drive data (`dq_oe` = 0), even with `oe_n` low.
- R2: After such a refresh, the column strobe may rise and then fall again while the row strobe stays low. That second fall opens a test access.
- R3: The row of a test access is the refresh counter value. The address pins at the row-strobe fall have no effect on it.
- R4: The column of a test access is the address sampled on the edge where the column strobe's second fall is seen. Address changes later in the same access are ignored.
- R5: The refresh counter is 10 bits wide. It increments by one, modulo 1024, on the edge where the row strobe rise that ends a refresh cycle is seen. From 1023 it wraps to 0.
- R6: A row strobe fall is sampled while the column strobe was high on the previous edge. This is a row-only cycle: it loads the counter with the address pins and does not increment it. A column strobe fall inside a row-only cycle opens no access.
- R7: If `we_n` is low on the edge that opens the test access, `dq_in` is written to the addressed location, and the bus is not driven for that access.
- R8: If `we_n` is high on the opening edge, the access is a read. While `oe_n` is low, `dq_out` carries the stored 4-bit word and `dq_oe` = 1. While `oe_n` is high, `dq_oe` = 0.
- R9: During a read access, a falling `we_n` writes `dq_in` to the same location. This is a read-modify-write. After it, `dq_oe` stays 0 for the rest of the access.
- R10: When a row strobe rise is seen, the block returns to idle. Column strobe activity with the row strobe high never drives the bus.
- R11: The array location is selected by the low `ARR_ROW_W` bits of the row (default 5) and the low `ARR_COL_W` bits of the column (default 3). Columns that differ only above bit 2 alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Multiplexed address pins |
| dq_in | input | 4 | Write data |
| dq_out | output | 4 | Read data |
| dq_oe | output | 1 | Read data drive enable; 0 stands for high impedance |

## Verification
On every cycle, the assertions check the sequencing decisions: refresh versus row-only decode, counter load and increment, entry into the test access, column hold, output gating by the output enable, and the return to idle. Only the scenarios can show that the test access actually reaches the row named by the counter. They do this by writing a pattern over a full sweep of consecutive refresh rows and checking it with read-modify-write. The same holds for the counter wrap from 1023 to 0 and for column aliasing in the reduced array.

// File: rtl/cbr_test_pkg.sv
// Package: shared state encoding for the refresh-counter test controller.
// Assumes nothing beyond IEEE 1800-2017 enums.
package cbr_test_pkg;

    // Controller phases within one row-strobe period
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // row strobe high, nothing open
        ST_RONLY = 3'd1,   // row-only cycle in progress
        ST_CBR   = 3'd2,   // refresh decoded, column strobe still low
        ST_GAP   = 3'd3,   // column strobe high after refresh
        ST_TEST  = 3'd4    // test access open
    } cbr_state_t;

endpackage

// File: rtl/cbr_edge.sv
// Module: cbr_edge
// Registers N active-low strobes and reports falling and rising edges.
// Assumes strobes are already synchronous to clk; reset value is inactive (1).
module cbr_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] prev,
    output logic [N-1:0] fell,
    output logic [N-1:0] rose
);

    // Keep last sampled level of each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= sig;
    end

    // Edge flags per strobe
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_edge
            assign fell[gi] = prev[gi] & ~sig[gi];
            assign rose[gi] = ~prev[gi] & sig[gi];
        end
    endgenerate

endmodule

// File: rtl/cbr_refcnt.sv
// Module: cbr_refcnt
// Internal refresh row counter; loadable, increments modulo 2**W.
// Assumes load and inc are never requested in the same cycle.
module cbr_refcnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         inc,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Counter register: load wins, else step by one with natural wrap
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
        else if (inc)  q <= q + 1'b1;
    end

endmodule

// File: rtl/cbr_array.sv
// Module: cbr_array
// Small behavioural storage: one write port, combinational read port.
// Assumes index widths are small; contents are not reset.
module cbr_array #(
    parameter int RW = 5,
    parameter int CW = 3,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] row,
    input  logic [CW-1:0] col,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd
);

    localparam int DEPTH = 1 << (RW + CW);

    logic [DW-1:0] mem [DEPTH];

    // Write the addressed word
    always_ff @(posedge clk) begin
        if (we) mem[{row, col}] <= wd;
    end

    // Read the addressed word
    assign rd = mem[{row, col}];

endmodule

// File: rtl/cbr_test_ctrl.sv
// Module: cbr_test_ctrl
// Decodes refresh and row-only cycles from sampled strobes, keeps the refresh
// row counter, and opens test accesses whose row is the counter value.
// Assumes strobes are synchronous to clk; timing parameters are not modelled.
module cbr_test_ctrl
    import cbr_test_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DQ_W      = 4,
    parameter int ARR_ROW_W = 5,
    parameter int ARR_COL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe
);

    localparam int I_RAS = 2;
    localparam int I_CAS = 1;
    localparam int I_WE  = 0;

    cbr_state_t        st, st_nx;
    logic [2:0]        stb_prev, stb_fell, stb_rose;
    logic [ADDR_W-1:0] rf_row;
    logic [ADDR_W-1:0] col_q;
    logic              acc_wr;
    logic              cnt_load, cnt_inc;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_col;
    logic              in_cbr;

    cbr_edge #(.N(3)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  ({ras_n, cas_n, we_n}),
        .prev (stb_prev),
        .fell (stb_fell),
        .rose (stb_rose)
    );

    cbr_refcnt #(.W(ADDR_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (cnt_load),
        .inc  (cnt_inc),
        .d    (addr),
        .q    (rf_row)
    );

    cbr_array #(.RW(ARR_ROW_W), .CW(ARR_COL_W), .DW(DQ_W)) u_arr (
        .clk(clk),
        .we (mem_we),
        .row(rf_row[ARR_ROW_W-1:0]),
        .col(mem_col[ARR_COL_W-1:0]),
        .wd (dq_in),
        .rd (dq_out)
    );

    // Refresh-family states that advance the counter when the cycle closes
    assign in_cbr = (st == ST_CBR) || (st == ST_GAP) || (st == ST_TEST);

    // Column comes from the pins on the opening edge, from the latch afterwards
    assign mem_col = (st == ST_TEST) ? col_q : addr;

    // Next-state, counter and write decisions
    always_comb begin
        st_nx    = st;
        cnt_load = 1'b0;
        cnt_inc  = 1'b0;
        mem_we   = 1'b0;
        if (stb_rose[I_RAS]) begin
            st_nx   = ST_IDLE;
            cnt_inc = in_cbr;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (stb_fell[I_RAS]) begin
                        if (!stb_prev[I_CAS]) begin
                            st_nx = ST_CBR;
                        end else begin
                            st_nx    = ST_RONLY;
                            cnt_load = 1'b1;
                        end
                    end
                end
                ST_CBR: begin
                    if (stb_rose[I_CAS]) st_nx = ST_GAP;
                end
                ST_GAP: begin
                    if (stb_fell[I_CAS]) begin
                        st_nx  = ST_TEST;
                        mem_we = ~we_n;
                    end
                end
                ST_TEST: begin
                    if (stb_rose[I_CAS])                  st_nx  = ST_GAP;
                    else if (stb_fell[I_WE] && !acc_wr) mem_we = 1'b1;
                end
                default: st_nx = st;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Latch the column and the write/read kind when an access opens
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q  <= '0;
            acc_wr <= 1'b0;
        end else if (st == ST_GAP && st_nx == ST_TEST) begin
            col_q  <= addr;
            acc_wr <= ~we_n;
        end else if (st == ST_TEST && mem_we) begin
            acc_wr <= 1'b1;
        end
    end

    // Drive read data only in an open read access with output enable low
    assign dq_oe = (st == ST_TEST) && !acc_wr && !oe_n && !ras_n;

endmodule

// File: rtl/cbr_test_chk.sv
// Module: cbr_test_chk
// Checker bound into cbr_test_ctrl; relates strobes, counter and state.
// Assumes the bench holds ras_n high during reset.
module cbr_test_chk
    import cbr_test_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic              dq_oe,
    input cbr_state_t        st,
    input logic [ADDR_W-1:0] rf_row,
    input logic [ADDR_W-1:0] col_q
);

    AST_CBR_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !ras_n && $past(ras_n) && !$past(cas_n)) |=> (st == ST_CBR)); // R1

    AST_TEST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP && !ras_n && !cas_n && $past(cas_n)) |=> (st == ST_TEST)); // R2

    AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TEST && $past(st) == ST_TEST) |-> $stable(col_q)); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_CBR || st == ST_GAP || st == ST_TEST) && ras_n && !$past(ras_n))
        |=> (rf_row == $past(rf_row) + 1'b1)); // R5

    AST_RONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !ras_n && $past(ras_n) && $past(cas_n)) |=> (rf_row == $past(addr))); // R6

    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!oe_n && !ras_n && st == ST_TEST)); // R8

    AST_IDLE_RAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && $past(ras_n)) |-> (st == ST_IDLE)); // R10

endmodule

bind cbr_test_ctrl cbr_test_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .oe_n  (oe_n),
    .addr  (addr),
    .dq_oe (dq_oe),
    .st    (st),
    .rf_row(rf_row),
    .col_q (col_q)
);

// File: tb/cbr_test_ctrl_tb.sv
// Bench: sweeps refresh rows with write, read-modify-write and read passes,
// then probes counter wrap, column aliasing and idle behaviour.
module cbr_test_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ras_n, cas_n, we_n, oe_n;
    logic [9:0] addr;
    logic [3:0] dq_in;
    logic [3:0] dq_out;
    logic       dq_oe;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done  = 1'b0;

    always #2.5 clk = ~clk;

    cbr_test_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // Compare one value and report
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pat(input int r, input int c);
        return 4'((r * 3 + c * 5 + 1) & 15);
    endfunction

    // Row-only cycle: loads the counter with v
    task automatic ras_only(input logic [9:0] v);
        @(negedge clk); cas_n = 1'b1; addr = v; ras_n = 1'b0;
        @(negedge clk); ras_n = 1'b1; addr = 10'h2A5;
        @(negedge clk);
    endtask

    // Refresh cycle followed by one test access
    task automatic cbr_acc(input logic [9:0] col, input bit do_wr, input logic [3:0] wd,
                           input logic [3:0] rd_exp, input bit do_rmw, input logic [3:0] md);
        @(negedge clk); cas_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk); ras_n = 1'b0; addr = ~col;       // R3: pins at row fall are junk
        @(negedge clk); chk("R1", dq_oe, 0); cas_n = 1'b1;
        @(negedge clk); cas_n = 1'b0; addr = col; we_n = !do_wr; dq_in = wd; oe_n = 1'b1;
        @(negedge clk); chk("R8", dq_oe, 0); oe_n = 1'b0; addr = col ^ 10'h3F5; // R4
        @(negedge clk);
        if (do_wr) chk("R7", dq_oe, 0);
        else begin
            chk("R8", dq_oe, 1);
            chk("R3", dq_out, rd_exp);
        end
        if (do_rmw) begin we_n = 1'b0; dq_in = md; end
        @(negedge clk);
        if (do_rmw) chk("R9", dq_oe, 0);
        we_n = 1'b1; cas_n = 1'b1;
        @(negedge clk); ras_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; dq_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset", dq_oe, 0);

        // R7: write pattern over 32 consecutive refresh rows
        ras_only(10'd0);
        for (int r = 0; r < 32; r++) cbr_acc(10'd2, 1'b1, pat(r, 2), 4'h0, 1'b0, 4'h0);
        // R9/R5: read-modify-write over the same rows
        ras_only(10'd0);
        for (int r = 0; r < 32; r++) cbr_acc(10'd2, 1'b0, 4'h0, pat(r, 2), 1'b1, ~pat(r, 2));
        // R8: plain read of the inverted data
        ras_only(10'd0);
        for (int r = 0; r < 32; r++) cbr_acc(10'd2, 1'b0, 4'h0, ~pat(r, 2), 1'b0, 4'h0);

        // R11: column 9 aliases column 1 in row 4
        ras_only(10'd4);
        cbr_acc(10'd9, 1'b1, 4'h6, 4'h0, 1'b0, 4'h0);
        ras_only(10'd4);
        cbr_acc(10'd1, 1'b0, 4'h0, 4'h6, 1'b0, 4'h0);   // R11

        // R5: counter wraps 1023 -> 0; R6 load without increment
        ras_only(10'd1023);
        cbr_acc(10'd0, 1'b1, 4'hA, 4'h0, 1'b0, 4'h0);
        cbr_acc(10'd0, 1'b1, 4'h3, 4'h0, 1'b0, 4'h0);
        ras_only(10'd1023);
        cbr_acc(10'd0, 1'b0, 4'h0, 4'hA, 1'b0, 4'h0);   // R6
        cbr_acc(10'd0, 1'b0, 4'h0, 4'h3, 1'b0, 4'h0);   // R5

        // R10: column strobe with row strobe high drives nothing
        @(negedge clk); cas_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); chk("R10", dq_oe, 0);
        cas_n = 1'b1;
        @(negedge clk); chk("R10", dq_oe, 0);
        // R6: column strobe inside a row-only cycle opens no access
        ras_n = 1'b0; addr = 10'd5;
        @(negedge clk); cas_n = 1'b0;
        @(negedge clk); chk("R6", dq_oe, 0);
        @(negedge clk); chk("R6", dq_oe, 0);
        cas_n = 1'b1; ras_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule